// File: doc/BRIEF.md
# Multi-Lane SPI Weight Distributor

This block takes one stream of per-element beam weights, each a 6-bit phase code and a 6-bit amplitude code, and fans it out to a row of beamformer chips over parallel SPI lanes. The words are dealt round-robin: the first word of a frame goes to lane 0, the next to lane 1, and so on. Every lane therefore carries the same number of words, and all lanes shift in lockstep from one shared bit clock and one shared chip select. The bit clock is made by dividing the system clock.

Each lane has a small FIFO. When any lane's FIFO is full, the upstream source is held off. A word slot starts on all lanes at once, and only when every lane holds a word. This keeps the lanes aligned, so they all finish together.

After the last bit of the frame, chip select is released. One system cycle later, a single load strobe two bit-clock periods long tells every chip to apply its new weights at the same moment. The busy output covers the whole update, from the first accepted word to the end of that strobe.

Top module: `weight_spi_fanout`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, spi_mosi is all 0, load_strobe is 0, busy is 0 and in_ready is 1.
- R2: The k-th word accepted in a frame (k counted from 0) is sent on lane k mod NUM_LANES. Each lane sends its words in the order they were accepted.
- R3: A word is 12 bits, {phase[5:0], amp[5:0]}, with phase in bits 11:6. It is shifted out MSB first, so the phase MSB is the first bit on the wire.
- R4: spi_sclk idles low. Each bit has spi_sclk low for CLK_DIV/2 system cycles and then high for CLK_DIV/2 system cycles. spi_mosi changes only while spi_sclk is low and holds steady while it is high (mode 0, sampled on the rising edge).
- R5: All lanes shift their j-th word on the same spi_sclk edges. A word slot starts only when every lane has a word buffered.
- R6: spi_cs_n goes low for the whole frame, including any stall between words. It rises only after the last bit of the last word. spi_sclk pulses only while spi_cs_n is low.
- R7: in_ready is 0 while any lane FIFO is full. Once NUM_ELEMS words of a frame have been accepted, in_ready stays 0 until the frame completes, and in_valid has no effect during that time.
- R8: One system cycle after spi_cs_n rises, load_strobe goes high for exactly 2*CLK_DIV system cycles (two bit periods). It fires exactly once per frame, after every lane has sent all its words.
- R9: busy goes to 1 in the cycle after the first word of a frame is accepted. It stays 1 while load_strobe is high and goes to 0 in the same cycle that load_strobe goes to 0.
- R10: A frame started after busy falls behaves exactly like the first one, beginning again at lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Block can accept a word |
| in_phase | input | 6 | Phase code of the offered word |
| in_amp | input | 6 | Amplitude code of the offered word |
| spi_sclk | output | 1 | Shared SPI bit clock |
| spi_cs_n | output | 1 | Shared active-low chip select |
| spi_mosi | output | NUM_LANES | Serial data, one bit per lane |
| load_strobe | output | 1 | Common weight-apply strobe |
| busy | output | 1 | Frame update in progress |

## Verification
The bench builds the block with 4 lanes, 16 elements per frame, a clock divide of 4 and FIFOs 2 words deep. With only 4 words per lane against FIFOs that hold 2, a source that offers a word every cycle runs into backpressure within a few words. The short frames also mean the load strobe, the release of chip select and the restart of a second frame all happen within a few hundred cycles. The second frame is fed with long gaps so the lanes run dry. This exercises the stall state, in which chip select must stay low and the bit clock must stop.

// File: rtl/wdist_pkg.sv
package wdist_pkg;

    localparam int PHASE_W = 6;
    localparam int AMP_W   = 6;
    localparam int WORD_W  = PHASE_W + AMP_W;

    // Phase code occupies the upper bits and is shifted first.
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [AMP_W-1:0]   amp;
    } weight_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_SHIFT,
        SQ_GAP,
        SQ_STROBE
    } seq_state_e;

    function automatic int unsigned width_of(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wdist_fifo.sv
module wdist_fifo
    import wdist_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  weight_t din,
    input  logic    pop,
    output weight_t dout,
    output logic    full,
    output logic    empty
);
    localparam int AW = width_of(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    weight_t         mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   count;

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/wdist_lane.sv
module wdist_lane
    import wdist_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  weight_t din,
    input  logic    load,
    input  logic    shift,
    output logic    full,
    output logic    empty,
    output logic    mosi
);
    weight_t             head;
    logic [WORD_W-1:0]   shreg;

    wdist_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (din),
        .pop   (load),
        .dout  (head),
        .full  (full),
        .empty (empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= head;
        end else if (shift) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

    assign mosi = shreg[WORD_W-1];

endmodule

// File: rtl/wdist_seq.sv
module wdist_seq
    import wdist_pkg::*;
#(
    parameter int CLK_DIV        = 4,
    parameter int WORDS_PER_LANE = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic all_ready,
    output logic load,
    output logic shift,
    output logic sclk,
    output logic cs_active,
    output logic shifting,
    output logic strobe,
    output logic frame_done
);
    localparam int DIV_W   = width_of(CLK_DIV);
    localparam int BIT_W   = width_of(WORD_W);
    localparam int WCNT_W  = width_of(WORDS_PER_LANE);
    localparam int STB_LEN = 2 * CLK_DIV;
    localparam int STB_W   = width_of(STB_LEN);

    seq_state_e          state;
    logic [DIV_W-1:0]    div_cnt;
    logic [BIT_W-1:0]    bit_cnt;
    logic [WCNT_W-1:0]   word_cnt;
    logic [STB_W-1:0]    stb_cnt;

    logic div_end, bit_end, last_word, waiting;

    always_comb begin
        div_end    = (div_cnt == DIV_W'(CLK_DIV - 1));
        bit_end    = (bit_cnt == '0);
        last_word  = (word_cnt == WCNT_W'(WORDS_PER_LANE - 1));
        waiting    = (state == SQ_IDLE) || (state == SQ_WAIT);
        load       = (waiting && all_ready) ||
                     ((state == SQ_SHIFT) && div_end && bit_end && !last_word && all_ready);
        shift      = (state == SQ_SHIFT) && div_end && !bit_end;
        sclk       = (state == SQ_SHIFT) && (div_cnt >= DIV_W'(CLK_DIV / 2));
        cs_active  = (state == SQ_WAIT) || (state == SQ_SHIFT);
        shifting   = (state == SQ_SHIFT);
        strobe     = (state == SQ_STROBE);
        frame_done = strobe && (stb_cnt == STB_W'(STB_LEN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            div_cnt  <= '0;
            bit_cnt  <= '0;
            word_cnt <= '0;
            stb_cnt  <= '0;
        end else begin
            case (state)
                SQ_IDLE, SQ_WAIT: begin
                    if (all_ready) begin
                        state   <= SQ_SHIFT;
                        div_cnt <= '0;
                        bit_cnt <= BIT_W'(WORD_W - 1);
                    end
                end
                SQ_SHIFT: begin
                    div_cnt <= div_end ? '0 : div_cnt + 1'b1;
                    if (div_end) begin
                        if (!bit_end) begin
                            bit_cnt <= bit_cnt - 1'b1;
                        end else if (last_word) begin
                            word_cnt <= '0;
                            state    <= SQ_GAP;
                        end else begin
                            word_cnt <= word_cnt + 1'b1;
                            if (all_ready) begin
                                bit_cnt <= BIT_W'(WORD_W - 1);
                            end else begin
                                state <= SQ_WAIT;
                            end
                        end
                    end
                end
                SQ_GAP: begin
                    stb_cnt <= '0;
                    state   <= SQ_STROBE;
                end
                SQ_STROBE: begin
                    if (frame_done) begin
                        state <= SQ_IDLE;
                    end else begin
                        stb_cnt <= stb_cnt + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/weight_spi_fanout.sv
module weight_spi_fanout
    import wdist_pkg::*;
#(
    parameter int NUM_LANES  = 16,
    parameter int NUM_ELEMS  = 4096,
    parameter int CLK_DIV    = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [PHASE_W-1:0]   in_phase,
    input  logic [AMP_W-1:0]     in_amp,
    output logic                 spi_sclk,
    output logic                 spi_cs_n,
    output logic [NUM_LANES-1:0] spi_mosi,
    output logic                 load_strobe,
    output logic                 busy
);
    localparam int WORDS_PER_LANE = NUM_ELEMS / NUM_LANES;
    localparam int LANE_W         = width_of(NUM_LANES);
    localparam int ELEM_W         = width_of(NUM_ELEMS);

    logic [LANE_W-1:0]    lane_sel;
    logic [ELEM_W-1:0]    elem_cnt;
    logic                 frame_loaded;
    logic                 busy_r;
    logic [NUM_LANES-1:0] lane_full;
    logic [NUM_LANES-1:0] lane_empty;
    logic [NUM_LANES-1:0] lane_mosi;
    logic                 any_full, all_ready, accept;
    logic                 seq_load, seq_shift, seq_sclk, seq_cs, seq_shifting;
    logic                 seq_strobe, seq_done;
    weight_t              in_word;

    assign in_word   = '{phase: in_phase, amp: in_amp};
    assign any_full  = |lane_full;
    assign all_ready = &(~lane_empty);
    assign in_ready  = !frame_loaded && !any_full;
    assign accept    = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_sel     <= '0;
            elem_cnt     <= '0;
            frame_loaded <= 1'b0;
            busy_r       <= 1'b0;
        end else begin
            if (accept) begin
                busy_r   <= 1'b1;
                lane_sel <= (lane_sel == LANE_W'(NUM_LANES - 1)) ? '0 : lane_sel + 1'b1;
                if (elem_cnt == ELEM_W'(NUM_ELEMS - 1)) begin
                    elem_cnt     <= '0;
                    frame_loaded <= 1'b1;
                end else begin
                    elem_cnt <= elem_cnt + 1'b1;
                end
            end
            if (seq_done) begin
                busy_r       <= 1'b0;
                frame_loaded <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        wdist_lane #(.FIFO_DEPTH(FIFO_DEPTH)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .push  (accept && (lane_sel == LANE_W'(g))),
            .din   (in_word),
            .load  (seq_load),
            .shift (seq_shift),
            .full  (lane_full[g]),
            .empty (lane_empty[g]),
            .mosi  (lane_mosi[g])
        );
    end

    wdist_seq #(
        .CLK_DIV        (CLK_DIV),
        .WORDS_PER_LANE (WORDS_PER_LANE)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .all_ready  (all_ready),
        .load       (seq_load),
        .shift      (seq_shift),
        .sclk       (seq_sclk),
        .cs_active  (seq_cs),
        .shifting   (seq_shifting),
        .strobe     (seq_strobe),
        .frame_done (seq_done)
    );

    assign spi_sclk    = seq_sclk;
    assign spi_cs_n    = !seq_cs;
    assign spi_mosi    = seq_shifting ? lane_mosi : '0;
    assign load_strobe = seq_strobe;
    assign busy        = busy_r;

endmodule

// File: rtl/wdist_chk.sv
module wdist_chk #(
    parameter int NUM_LANES = 16,
    parameter int CLK_DIV   = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_ready,
    input logic                 any_full,
    input logic                 spi_sclk,
    input logic                 spi_cs_n,
    input logic [NUM_LANES-1:0] spi_mosi,
    input logic                 load_strobe,
    input logic                 busy
);
    localparam int STB_LEN = 2 * CLK_DIV;

    int stb_run;

    always_ff @(posedge clk) begin
        if (rst || !load_strobe) begin
            stb_run <= 0;
        end else begin
            stb_run <= stb_run + 1;
        end
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (spi_cs_n && !spi_sclk && !load_strobe && !busy && in_ready));

    a_r4_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    a_r6_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_cs_n);

    a_r7_full_holds_off: assert property (@(posedge clk) disable iff (rst)
        any_full |-> !in_ready);

    a_r7_idle_ready: assert property (@(posedge clk) disable iff (rst)
        !busy |-> in_ready);

    a_r8_strobe_after_cs: assert property (@(posedge clk) disable iff (rst)
        $rose(load_strobe) |-> (spi_cs_n && $past(spi_cs_n)));

    a_r8_strobe_bounded: assert property (@(posedge clk) disable iff (rst)
        load_strobe |-> (stb_run < STB_LEN));

    a_r8_strobe_full_len: assert property (@(posedge clk) disable iff (rst)
        $fell(load_strobe) |-> ($past(stb_run) == STB_LEN - 1));

    a_r9_busy_covers_strobe: assert property (@(posedge clk) disable iff (rst)
        load_strobe |-> busy);

    a_r9_busy_ends_with_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(load_strobe) |-> !busy);

endmodule

bind weight_spi_fanout wdist_chk #(
    .NUM_LANES (NUM_LANES),
    .CLK_DIV   (CLK_DIV)
) u_wdist_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .any_full    (any_full),
    .spi_sclk    (spi_sclk),
    .spi_cs_n    (spi_cs_n),
    .spi_mosi    (spi_mosi),
    .load_strobe (load_strobe),
    .busy        (busy)
);

// File: tb/tb_weight_spi_fanout.sv
module tb_weight_spi_fanout;

    localparam int NL  = 4;
    localparam int NE  = 16;
    localparam int CD  = 4;
    localparam int FD  = 2;
    localparam int W   = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [5:0]    in_phase = '0;
    logic [5:0]    in_amp = '0;
    logic          spi_sclk, spi_cs_n, load_strobe, busy;
    logic [NL-1:0] spi_mosi;

    always #4 clk = ~clk;

    weight_spi_fanout #(
        .NUM_LANES (NL),
        .NUM_ELEMS (NE),
        .CLK_DIV   (CD),
        .FIFO_DEPTH(FD)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_phase   (in_phase),
        .in_amp     (in_amp),
        .spi_sclk   (spi_sclk),
        .spi_cs_n   (spi_cs_n),
        .spi_mosi   (spi_mosi),
        .load_strobe(load_strobe),
        .busy       (busy)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [W-1:0] expq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Monitor: rebuilds words from the wire and compares against the scoreboard.
    logic          prev_sclk = 1'b0, prev_stb = 1'b0, prev_cs = 1'b1;
    logic [W-1:0]  rx [NL];
    logic [NL-1:0] cap;
    int            bitn = 0, hi_run = 0, stb_run = 0, strobes = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (spi_sclk && !prev_sclk) begin
                check(!spi_cs_n, "R6", "cs_n at sclk rise", int'(spi_cs_n), 0);
                for (int l = 0; l < NL; l++) rx[l] = {rx[l][W-2:0], spi_mosi[l]};
                cap = spi_mosi;
                hi_run = 1;
                bitn++;
                if (bitn == W) begin
                    bitn = 0;
                    for (int l = 0; l < NL; l++) begin
                        if (expq.size() == 0) begin
                            check(0, "R2 R7", "unexpected extra word", int'(rx[l]), 0);
                        end else begin
                            logic [W-1:0] e;
                            e = expq.pop_front();
                            // R2 R3 R5: lane l's word in this slot, MSB (phase) first
                            check(rx[l] == e, "R2 R3 R5", $sformatf("lane %0d word", l),
                                  int'(rx[l]), int'(e));
                        end
                    end
                end
            end else if (spi_sclk) begin
                hi_run++;
                check(spi_mosi == cap, "R4", "mosi stable while sclk high",
                      int'(spi_mosi), int'(cap));
            end
            if (!spi_sclk && prev_sclk)
                check(hi_run == CD/2, "R4", "sclk high time", hi_run, CD/2);
            if (spi_cs_n && !prev_cs)
                check(expq.size() == 0 && bitn == 0, "R6", "cs_n rose before frame end",
                      expq.size(), 0);
            if (load_strobe && !prev_stb) begin
                strobes++;
                stb_run = 1;
                check(spi_cs_n && prev_cs, "R8", "cs_n high before strobe", int'(prev_cs), 1);
                check(expq.size() == 0, "R8", "words left at strobe", expq.size(), 0);
            end else if (load_strobe) begin
                stb_run++;
            end
            if (!load_strobe && prev_stb) begin
                check(stb_run == 2*CD, "R8", "strobe length", stb_run, 2*CD);
                check(!busy, "R9", "busy after strobe end", int'(busy), 0);
            end
            prev_sclk = spi_sclk;
            prev_stb  = load_strobe;
            prev_cs   = spi_cs_n;
        end
    end

    // Driver: offers one frame, pushing each accepted word into the scoreboard.
    task automatic send_frame(input int seed, input int gap_every, input int gap_len,
                              output int stalls);
        stalls = 0;
        @(negedge clk);
        for (int i = 0; i < NE; i++) begin
            if (gap_every > 0 && i > 0 && (i % gap_every) == 0) begin
                in_valid = 1'b0;
                repeat (gap_len) @(negedge clk);
            end
            in_valid = 1'b1;
            in_phase = 6'((i * 5 + seed) & 63);
            in_amp   = 6'((i * 11 + seed * 3 + 7) & 63);
            while (!in_ready) begin
                stalls++;
                @(negedge clk);
            end
            expq.push_back({in_phase, in_amp});
            @(negedge clk);
            if (i == 0) check(busy, "R9", "busy after first accept", int'(busy), 1);
        end
        in_valid = 1'b0;
        check(!in_ready, "R7", "ready after full frame", int'(in_ready), 0);
        // R7: extra offers while the frame is loaded are ignored
        in_valid = 1'b1;
        in_phase = 6'h3f;
        in_amp   = 6'h3f;
        for (int c = 0; c < 30; c++) begin
            if (in_ready) check(0, "R7", "ready during loaded frame", 1, 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "ALL", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int st1, st2;
        for (int l = 0; l < NL; l++) rx[l] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n, "R1", "reset cs_n", int'(spi_cs_n), 1);
        check(!spi_sclk, "R1", "reset sclk", int'(spi_sclk), 0);
        check(spi_mosi == '0, "R1", "reset mosi", int'(spi_mosi), 0);
        check(!load_strobe, "R1", "reset strobe", int'(load_strobe), 0);
        check(!busy, "R1", "reset busy", int'(busy), 0);
        check(in_ready, "R1", "reset in_ready", int'(in_ready), 1);

        send_frame(3, 0, 0, st1);
        check(st1 > 0, "R7", "backpressure seen with continuous source", st1, 1);
        check(strobes == 1, "R8", "strobes after frame 1", strobes, 1);

        // R10: second frame with starving gaps, restarts at lane 0
        send_frame(21, 3, 40, st2);
        check(strobes == 2, "R10", "strobes after frame 2", strobes, 2);
        check(expq.size() == 0, "R10", "scoreboard drained", expq.size(), 0);
        check(in_ready && !busy, "R10", "idle after frame 2", int'(in_ready), 1);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule